// File: doc/BRIEF.md
# Windowed Toggle Watchdog Supervisor

This block supervises a host processor through one trigger line that the software must toggle on a strict schedule. Both rising and falling transitions count as triggers. Once supervision starts, the first transition has a single upper deadline. Each later transition must fall inside a closed window of elapsed time, measured from the transition before it. A transition that comes too soon, one that flips back almost at once, or a missing one makes the block drive a reset pulse of fixed length at once. When the pulse ends, the block arms itself again in the first-trigger phase.

All timing is counted in ticks of a slow enable, nominally 32.768 kHz, that is qualified against the fast system clock. The trigger passes through a two-flop synchroniser before its edges are detected. A two-bit code records why the most recent pulse was raised, and it stays readable after the host comes out of reset. A disable input holds supervision off. A clear input restarts supervision from the first-trigger phase. The reset input `rst_n` is asynchronous on assertion and must be deasserted synchronously to `clk` by the surrounding logic.

Top module: `wdog_window_sup`

## Requirements
- R1: While `rst_n` is low and just after it is released, `rst_pulse_o` is 0, `cause_o` is 2'b00 and supervision is in the first-trigger phase with zero ticks elapsed.
- R2: In the first-trigger phase, a trigger edge seen with fewer than FIRST_MAX ticks elapsed moves supervision into the window phase. Reaching FIRST_MAX ticks with no edge raises a pulse with cause 2'b00 (first timeout).
- R3: In the window phase, an edge seen with between WIN_MIN and WIN_MAX ticks elapsed, both limits included, is accepted and restarts the tick count without a pulse.
- R4: In the window phase, an edge seen with at least GLITCH_TICKS but fewer than WIN_MIN ticks elapsed raises a pulse with cause 2'b01 (early).
- R5: In the window phase, reaching WIN_MAX+1 ticks with no edge raises a pulse with cause 2'b10 (late).
- R6: In the window phase, an edge seen with fewer than GLITCH_TICKS ticks elapsed is a malformed pulse and raises a pulse with cause 2'b11 (glitch).
- R7: Rising and falling transitions of `trig_in` count equally as trigger edges.
- R8: `rst_pulse_o` stays high for PULSE_TICKS ticks and then falls, and supervision returns to the first-trigger phase. Trigger edges are ignored while the pulse is high.
- R9: While `wd_disable` is high, no pulse is raised and supervision is held at the start of the first-trigger phase. It resumes from there when `wd_disable` is released.
- R10: A cycle with `wd_clear` high ends any pulse in progress and restarts the first-trigger phase with zero ticks elapsed.
- R11: `cause_o` changes only in the cycle a pulse starts, and it keeps its value through clear, disable and later good triggers.
- R12: A change on `trig_in` is sampled through two flops, and its edge acts on the supervision state at the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| tick_en | input | 1 | One-cycle qualifier marking each timing tick |
| trig_in | input | 1 | Asynchronous trigger line from the host |
| wd_disable | input | 1 | Holds supervision off while high |
| wd_clear | input | 1 | Restarts supervision in the first-trigger phase |
| rst_pulse_o | output | 1 | Reset pulse to the host |
| cause_o | output | 2 | Reason for the last pulse: 00 first timeout, 01 early, 10 late, 11 glitch |

## Verification
The bench builds the block with FIRST_MAX=20, WIN_MIN=8, WIN_MAX=12, GLITCH_TICKS=2 and PULSE_TICKS=4, and it issues a tick on every second clock. These values put every cause, the whole pulse length and the return to the first-trigger phase within a few hundred cycles. The windows are also short enough that one run can place triggers inside the window, just before it and long after it. A tick-level reference model is compared with both outputs on every clock. Directed checks confirm the cause code, the pulse width and the first-phase deadline counted from the end of a pulse.

// File: rtl/wsup_pkg.sv
package wsup_pkg;
  typedef enum logic [1:0] {
    PH_FIRST = 2'd0,
    PH_WIN   = 2'd1,
    PH_PULSE = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    CAUSE_FIRST_TO = 2'd0,
    CAUSE_EARLY    = 2'd1,
    CAUSE_LATE     = 2'd2,
    CAUSE_GLITCH   = 2'd3
  } cause_t;
endpackage

// File: rtl/wsup_sync.sv
// Trigger synchroniser with transition detector; edges are masked until the chain is filled.
module wsup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] chain_q, chain_d;
  logic [LEN-1:0] fill_q, fill_d;

  always_comb begin
    chain_d = {chain_q[LEN-2:0], async_i};
    fill_d  = {fill_q[LEN-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      fill_q  <= '0;
    end else begin
      chain_q <= chain_d;
      fill_q  <= fill_d;
    end
  end

  // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its previous value
  assign edge_o = fill_q[LEN-1] & (chain_q[STAGES-1] ^ chain_q[STAGES]);
endmodule

// File: rtl/wsup_tick_cnt.sv
module wsup_tick_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wsup_ctrl.sv
module wsup_ctrl
  import wsup_pkg::*;
#(
  parameter int CNT_W        = 15,
  parameter int FIRST_MAX    = 16384,
  parameter int WIN_MIN      = 6554,
  parameter int WIN_MAX      = 9830,
  parameter int GLITCH_TICKS = 2,
  parameter int PULSE_TICKS  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output phase_t           phase_o,
  output cause_t           cause_o
);
  localparam logic [CNT_W-1:0] L_FIRST = CNT_W'(FIRST_MAX);
  localparam logic [CNT_W-1:0] L_WMIN  = CNT_W'(WIN_MIN);
  localparam logic [CNT_W-1:0] L_WMAX  = CNT_W'(WIN_MAX);
  localparam logic [CNT_W-1:0] L_GLT   = CNT_W'(GLITCH_TICKS);
  localparam logic [CNT_W-1:0] L_PEND  = CNT_W'(PULSE_TICKS - 1);

  phase_t phase_q, phase_d;
  cause_t cause_q, cause_d;
  logic   viol;
  cause_t viol_code;

  always_comb begin
    phase_d   = phase_q;
    cause_d   = cause_q;
    cnt_clr_o = 1'b0;
    viol      = 1'b0;
    viol_code = cause_q;
    if (hold_i) begin
      phase_d   = PH_FIRST;
      cnt_clr_o = 1'b1;
    end else begin
      unique case (phase_q)
        PH_FIRST: begin
          if (cnt_i >= L_FIRST) begin
            viol      = 1'b1;
            viol_code = CAUSE_FIRST_TO;
          end else if (edge_i) begin
            phase_d   = PH_WIN;
            cnt_clr_o = 1'b1;
          end
        end
        PH_WIN: begin
          if (cnt_i > L_WMAX) begin
            viol      = 1'b1;
            viol_code = CAUSE_LATE;
          end else if (edge_i) begin
            if (cnt_i < L_GLT) begin
              viol      = 1'b1;
              viol_code = CAUSE_GLITCH;
            end else if (cnt_i < L_WMIN) begin
              viol      = 1'b1;
              viol_code = CAUSE_EARLY;
            end else begin
              cnt_clr_o = 1'b1;
            end
          end
        end
        PH_PULSE: begin
          if (tick_i && cnt_i == L_PEND) begin
            phase_d   = PH_FIRST;
            cnt_clr_o = 1'b1;
          end
        end
        default: begin
          phase_d   = PH_FIRST;
          cnt_clr_o = 1'b1;
        end
      endcase
      if (viol) begin
        phase_d   = PH_PULSE;
        cause_d   = viol_code;
        cnt_clr_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;
      cause_q <= CAUSE_FIRST_TO;
    end else begin
      phase_q <= phase_d;
      cause_q <= cause_d;
    end
  end

  assign phase_o = phase_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/wdog_window_sup.sv
module wdog_window_sup
  import wsup_pkg::*;
#(
  parameter int FIRST_MAX    = 16384,
  parameter int WIN_MIN      = 6554,
  parameter int WIN_MAX      = 9830,
  parameter int GLITCH_TICKS = 2,
  parameter int PULSE_TICKS  = 32,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       trig_in,
  input  logic       wd_disable,
  input  logic       wd_clear,
  output logic       rst_pulse_o,
  output logic [1:0] cause_o
);
  localparam int M1    = (FIRST_MAX > WIN_MAX + 1) ? FIRST_MAX : WIN_MAX + 1;
  localparam int MAXC  = (M1 > PULSE_TICKS) ? M1 : PULSE_TICKS;
  localparam int CNT_W = $clog2(MAXC + 2);

  logic             trig_edge;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt_q;
  phase_t           phase_q;
  cause_t           cause_q;

  wsup_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (trig_in),
    .edge_o  (trig_edge)
  );

  wsup_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .inc_i (tick_en),
    .cnt_o (cnt_q)
  );

  wsup_ctrl #(
    .CNT_W        (CNT_W),
    .FIRST_MAX    (FIRST_MAX),
    .WIN_MIN      (WIN_MIN),
    .WIN_MAX      (WIN_MAX),
    .GLITCH_TICKS (GLITCH_TICKS),
    .PULSE_TICKS  (PULSE_TICKS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_i    (trig_edge),
    .tick_i    (tick_en),
    .hold_i    (wd_disable | wd_clear),
    .cnt_i     (cnt_q),
    .cnt_clr_o (cnt_clr),
    .phase_o   (phase_q),
    .cause_o   (cause_q)
  );

  assign rst_pulse_o = (phase_q == PH_PULSE);
  assign cause_o     = cause_q;
endmodule

// File: rtl/wsup_chk.sv
module wsup_chk
  import wsup_pkg::*;
#(
  parameter int CNT_W        = 15,
  parameter int FIRST_MAX    = 16384,
  parameter int WIN_MAX      = 9830,
  parameter int PULSE_TICKS  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             wd_disable,
  input logic             wd_clear,
  input logic             rst_pulse_o,
  input logic [1:0]       cause_o,
  input phase_t           phase,
  input logic [CNT_W-1:0] cnt
);
  // R9 and R10: a hold request removes any pulse at the next edge
  assert_hold_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_disable || wd_clear) |=> !rst_pulse_o);

  // R9: a pulse never starts out of a disabled cycle
  assert_no_rise_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse_o) |-> !$past(wd_disable));

  // R11: cause code only moves when a pulse begins
  assert_cause_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(rst_pulse_o) |-> $stable(cause_o));

  // R8: pulse ends only after a tick or a hold request
  assert_pulse_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pulse_o) |-> ($past(tick_en) || $past(wd_disable) || $past(wd_clear)));

  // R8: tick count within a pulse stays below its length
  assert_pulse_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PULSE) |-> (cnt < CNT_W'(PULSE_TICKS)));

  // R5: window count never runs past the late limit
  assert_win_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WIN) |-> (cnt <= CNT_W'(WIN_MAX + 1)));

  // R2: first-phase count never runs past its deadline
  assert_first_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIRST) |-> (cnt <= CNT_W'(FIRST_MAX)));
endmodule

bind wdog_window_sup wsup_chk #(
  .CNT_W       (CNT_W),
  .FIRST_MAX   (FIRST_MAX),
  .WIN_MAX     (WIN_MAX),
  .PULSE_TICKS (PULSE_TICKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .wd_disable  (wd_disable),
  .wd_clear    (wd_clear),
  .rst_pulse_o (rst_pulse_o),
  .cause_o     (cause_o),
  .phase       (phase_q),
  .cnt         (cnt_q)
);

// File: tb/sim_wdog_window_sup.sv
`timescale 1ns/1ps
module sim_wdog_window_sup;
  localparam int FM = 20, WMIN = 8, WMAX = 12, GL = 2, PT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic trig_in = 1'b0;
  logic wd_disable = 1'b0;
  logic wd_clear = 1'b0;
  logic rst_pulse_o;
  logic [1:0] cause_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R1";
  bit pulse_seen = 1'b0;

  always #2 clk = ~clk;

  wdog_window_sup #(
    .FIRST_MAX(FM), .WIN_MIN(WMIN), .WIN_MAX(WMAX),
    .GLITCH_TICKS(GL), .PULSE_TICKS(PT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .trig_in(trig_in),
    .wd_disable(wd_disable), .wd_clear(wd_clear),
    .rst_pulse_o(rst_pulse_o), .cause_o(cause_o)
  );

  // tick on every second clock
  always @(negedge clk) tick_en <= ~tick_en;

  // behavioural reference: phase 0 first, 1 window, 2 pulse
  int m_ph = 0, m_cnt = 0, m_cause = 0;
  bit m1 = 0, m2 = 0, m3 = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_cause = 0; m1 = 0; m2 = 0; m3 = 0;
    end else begin
      bit e, clrc;
      int viol, nph;
      e = m2 ^ m3; m3 = m2; m2 = m1; m1 = trig_in;
      clrc = 0; viol = -1; nph = m_ph;
      if (wd_disable || wd_clear) begin
        nph = 0; clrc = 1;
      end else begin
        if (m_ph == 0) begin
          if (m_cnt >= FM) viol = 0;
          else if (e) begin nph = 1; clrc = 1; end
        end else if (m_ph == 1) begin
          if (m_cnt > WMAX) viol = 2;
          else if (e) begin
            if (m_cnt < GL) viol = 3;
            else if (m_cnt < WMIN) viol = 1;
            else clrc = 1;
          end
        end else begin
          if (tick_en && m_cnt == PT - 1) begin nph = 0; clrc = 1; end
        end
        if (viol >= 0) begin nph = 2; m_cause = viol; clrc = 1; end
      end
      m_cnt = clrc ? 0 : (tick_en ? m_cnt + 1 : m_cnt);
      m_ph = nph;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(rst_pulse_o == (m_ph == 2), cur_req, "model pulse", rst_pulse_o, m_ph == 2);
      check(cause_o == m_cause[1:0], cur_req, "model cause", cause_o, m_cause);
    end
    if (rst_pulse_o) pulse_seen = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic toggle();
    trig_in = ~trig_in;
  endtask

  task automatic wait_pulse(input int max_cyc, output bit found, output int waited);
    found = 0; waited = 0;
    while (!found && waited < max_cyc) begin
      @(negedge clk); waited++;
      if (rst_pulse_o) found = 1;
    end
  endtask

  task automatic wait_low();
    while (rst_pulse_o) @(negedge clk);
  endtask

  initial begin
    bit found;
    int waited, width;
    repeat (5) @(negedge clk);
    // R1: reset values
    check(rst_pulse_o == 0, "R1", "pulse in reset", rst_pulse_o, 0);
    check(cause_o == 2'b00, "R1", "cause in reset", cause_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rst_pulse_o == 0, "R1", "pulse after release", rst_pulse_o, 0);

    // R2 R3 R7 R12: good triggers, both directions
    cur_req = "R3/R7/R12";
    pulse_seen = 0;
    ticks(5); toggle();
    for (int i = 0; i < 5; i++) begin ticks(10); toggle(); end
    ticks(4);
    check(pulse_seen == 0, "R3", "no pulse for in-window toggles", pulse_seen, 0);
    check(pulse_seen == 0, "R7", "rise and fall both accepted", pulse_seen, 0);

    // R5: late trigger, then R8 pulse width with edge during pulse
    cur_req = "R5/R8";
    wait_pulse(60, found, waited);
    check(found, "R5", "late pulse raised", found, 1);
    check(cause_o == 2'b10, "R5", "late cause", cause_o, 2);
    toggle();
    width = 1;
    while (rst_pulse_o) begin @(negedge clk); if (rst_pulse_o) width++; end
    check(width >= 2*PT-1 && width <= 2*PT, "R8", "pulse width cycles", width, 2*PT);

    // R2: first-phase timeout counted from pulse end
    cur_req = "R2/R8";
    wait_pulse(100, found, waited);
    check(found, "R2", "first timeout pulse", found, 1);
    check(cause_o == 2'b00, "R2", "first timeout cause", cause_o, 0);
    check(waited >= 2*FM-1 && waited <= 2*FM+2, "R2", "first deadline cycles", waited, 2*FM);
    wait_low();

    // R4: early trigger
    cur_req = "R4";
    ticks(3); toggle(); ticks(5); toggle();
    wait_pulse(20, found, waited);
    check(found && cause_o == 2'b01, "R4", "early cause", cause_o, 1);
    wait_low();

    // R6: glitch
    cur_req = "R6";
    ticks(3); toggle(); repeat (2) @(negedge clk); toggle();
    wait_pulse(20, found, waited);
    check(found && cause_o == 2'b11, "R6", "glitch cause", cause_o, 3);
    wait_low();

    // R9 R11: disable holds off pulses, cause retained
    cur_req = "R9/R11";
    wd_disable = 1'b1;
    pulse_seen = 0;
    ticks(40);
    check(pulse_seen == 0, "R9", "no pulse while disabled", pulse_seen, 0);
    check(cause_o == 2'b11, "R11", "cause kept while disabled", cause_o, 3);
    wd_disable = 1'b0;
    ticks(5); toggle(); ticks(10); toggle(); ticks(3);
    check(pulse_seen == 0, "R9", "resumes in first phase", pulse_seen, 0);

    // R10: clear restarts first phase mid-window
    cur_req = "R10";
    ticks(6);
    wd_clear = 1'b1; @(negedge clk); wd_clear = 1'b0;
    ticks(16); toggle(); ticks(10); toggle(); ticks(3);
    check(pulse_seen == 0, "R10", "clear restarted first phase", pulse_seen, 0);
    wait_pulse(60, found, waited);
    check(found && cause_o == 2'b10, "R5", "late after clear run", cause_o, 2);
    wd_clear = 1'b1; @(negedge clk); wd_clear = 1'b0;
    check(rst_pulse_o == 0, "R10", "clear ends pulse", rst_pulse_o, 0);
    check(cause_o == 2'b10, "R11", "cause kept after clear", cause_o, 2);
    ticks(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule